// File: doc/BRIEF.md
# BCD Calendar Counter with Prescaler

This block is the counting core of a real-time clock. A prescaler divides the system clock down to a 128 Hz tick. The tick drives a 7-bit sub-second counter, and each wrap of that counter advances a chain of packed-BCD counters: seconds, minutes, hours, day of week, day of month, month and year. Month lengths and leap years are handled in hardware. The year is either a two-digit value covering 1999 to 2098 or a full four-digit value, chosen by the `FOUR_DIGIT_YEAR` parameter.

Software reaches the block through a byte-wide register port. It stops the clock, loads each field directly and then starts counting. It reads the fields back at any time. A sticky carry flag is set each time the seconds counter moves. Software clears the flag, reads every field, and repeats the read if the flag has come back set. That gives a consistent snapshot without freezing the counters. A 30-second adjust strobe rounds the seconds to the nearest whole minute.

Top module: `rtc_core`

## Requirements
- R1: After reset the registers read as follows.
  - Sub-second 0, seconds 0x00, minutes 0x00, hours 0x00, weekday 0x00.
  - Day of month 0x01, month 0x01, year-low 0x00.
  - Century 0x20 in four-digit mode and 0x00 in two-digit mode.
  - Control-1 0x00 and control-2 0x00, so the clock is stopped.
- R2: The register map is as follows.
  - Address 0: sub-second (read-only, 7 bits, zero-extended).
  - Addresses 1 to 6: seconds, minutes, hours, weekday, day, month.
  - Address 7: BCD year within the century.
  - Address 8: BCD century.
  - Address 9: control-1.
  - Address 10: control-2.
  - While the start bit is 0, a write to addresses 1 to 8 loads that field, and the field reads back as written.
- R3: While the start bit (control-2 bit 0) is 1, writes to addresses 1 to 8 are ignored.
- R4: While the start bit is 0, the prescaler, the sub-second counter and all calendar fields hold their values.
- R5: Writing control-2 with bit 1 set clears both the prescaler and the sub-second counter.
  - While running, the sub-second counter increments once every `PRESCALE_DIV` clocks.
  - Seconds advance on the wrap from 127 to 0. That edge is exactly 128×`PRESCALE_DIV` clock edges after a control-2 write that sets bits 0 and 1 together.
- R6: Seconds wrap 59→00 with a carry into minutes. Minutes wrap 59→00 with a carry into hours. Hours wrap 23→00 with a carry into the day. On that day carry, the weekday advances and wraps 6→0.
- R7: The day of month wraps to 1 after the month's last day.
  - The last day is 31, except 30 in months 04, 06, 09 and 11.
  - February ends on day 28, or day 29 in leap years.
  - In four-digit mode a year is a leap year when its year-within-century is a nonzero multiple of 4, or when that value is 00 and the century is a multiple of 4.
- R8: Month 12 wraps to 01 and carries into the year. In four-digit mode the year-low wraps 99→00 and carries into the century, which wraps 99→00.
- R9: In two-digit mode the following hold.
  - The year-low wraps 99→00.
  - Address 8 reads 0 and writes to it are ignored.
  - Year-low 00 counts as a leap year, because it stands for 2000.
- R10: Control-1 bit 7 is the carry flag.
  - It is set on every seconds advance and on every adjust.
  - Writing 0 to bit 7 clears it. Writing 1 leaves it unchanged.
  - When a set and a clear fall in the same cycle, the set wins.
  - The other control-1 bits read 0.
- R11: Writing control-2 with bit 2 set is a 30-second adjust.
  - Seconds from 00 to 29 become 00.
  - Seconds from 30 to 59 become 00 and carry into the minutes.
- R12: Control-2 bit 3 (clock valid) and bit 0 (start) are stored and read back. Bits 1 and 2 are strobes and always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr`, combinational |

## Verification
The assertions check every cycle for the following:
- The seconds wrap.
- The weekday wrap at midnight.
- The sub-second reset on each seconds advance.
- The carry flag rising after a seconds advance.
- Counters holding still while the clock is stopped.
- Seconds writes having no effect while running.

The directed scenarios cover the following:
- Month-length and leap-year decisions across several years, including century years, in both year modes.
- The exact edge on which the first second elapses after a prescaler reset.
- The full midnight-to-new-century cascade.
- The adjust rounding.
- The clear rules of the carry flag.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [3:0] ADDR_SUBSEC  = 4'd0;
  localparam logic [3:0] ADDR_SEC     = 4'd1;
  localparam logic [3:0] ADDR_MIN     = 4'd2;
  localparam logic [3:0] ADDR_HOUR    = 4'd3;
  localparam logic [3:0] ADDR_WDAY    = 4'd4;
  localparam logic [3:0] ADDR_MDAY    = 4'd5;
  localparam logic [3:0] ADDR_MON     = 4'd6;
  localparam logic [3:0] ADDR_YEAR_LO = 4'd7;
  localparam logic [3:0] ADDR_YEAR_HI = 4'd8;
  localparam logic [3:0] ADDR_CTL1    = 4'd9;
  localparam logic [3:0] ADDR_CTL2    = 4'd10;

  localparam int CTL2_START  = 0;
  localparam int CTL2_CLRPRE = 1;
  localparam int CTL2_ADJ    = 2;
  localparam int CTL2_VALID  = 3;
  localparam int CTL1_CARRY  = 7;

  localparam int SUBSEC_W = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic       secTick;
    logic       adjust;
    logic       loadEn;
    logic [3:0] loadSel;
    logic [7:0] loadData;
  } strobeT;

  // calendar state, every field packed BCD
  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] mon;
    logic [7:0] yLo;
    logic [7:0] yHi;
  } calT;

  function automatic logic [7:0] bcdInc(input logic [7:0] x);
    if (x[3:0] >= 4'd9) return {x[7:4] + 4'd1, 4'd0};
    else                return {x[7:4], x[3:0] + 4'd1};
  endfunction

  // true when a two-digit BCD value is a multiple of four
  function automatic logic bcdDiv4(input logic [7:0] x);
    if (x[4]) return (x[3:0] == 4'd2) || (x[3:0] == 4'd6);
    else      return (x[3:0] == 4'd0) || (x[3:0] == 4'd4) || (x[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int PRESCALE_DIV = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [3:0]          regAddr,
  input  logic                regWrEn,
  input  logic [7:0]          regWrData,
  output strobeT              strobe,
  output logic [SUBSEC_W-1:0] subSec,
  output logic                carryFlag,
  output logic                startBit,
  output logic                validBit
);

  localparam int PW = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(PRESCALE_DIV - 1);
  localparam logic [SUBSEC_W-1:0] SUBSEC_LAST = '1;

  logic [PW-1:0] prescCnt;
  logic          prescTick;
  logic          ctl1Wr;
  logic          ctl2Wr;
  logic          prescClr;
  logic          timeAddr;

  always_comb begin
    ctl1Wr    = regWrEn && (regAddr == ADDR_CTL1);
    ctl2Wr    = regWrEn && (regAddr == ADDR_CTL2);
    prescClr  = ctl2Wr && regWrData[CTL2_CLRPRE];
    prescTick = startBit && (prescCnt == PRESC_LAST);
    timeAddr  = (regAddr >= ADDR_SEC) && (regAddr <= ADDR_YEAR_HI);

    strobe.secTick  = prescTick && (subSec == SUBSEC_LAST) && !prescClr;
    strobe.adjust   = ctl2Wr && regWrData[CTL2_ADJ];
    strobe.loadEn   = regWrEn && !startBit && timeAddr;
    strobe.loadSel  = regAddr;
    strobe.loadData = regWrData;
  end

  // prescaler and sub-second counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescCnt <= '0;
      subSec   <= '0;
    end else if (prescClr) begin
      prescCnt <= '0;
      subSec   <= '0;
    end else if (prescTick) begin
      prescCnt <= '0;
      subSec   <= subSec + SUBSEC_W'(1);
    end else if (startBit) begin
      prescCnt <= prescCnt + PW'(1);
    end
  end

  // stored control bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startBit <= 1'b0;
      validBit <= 1'b0;
    end else if (ctl2Wr) begin
      startBit <= regWrData[CTL2_START];
      validBit <= regWrData[CTL2_VALID];
    end
  end

  // sticky carry: set has priority over a software clear
  always_ff @(posedge clk) begin
    if (!rstN)                                       carryFlag <= 1'b0;
    else if (strobe.secTick || strobe.adjust)        carryFlag <= 1'b1;
    else if (ctl1Wr && !regWrData[CTL1_CARRY])       carryFlag <= 1'b0;
  end

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter bit FOUR_DIGIT_YEAR = 1'b1
) (
  input  logic   clk,
  input  logic   rstN,
  input  strobeT strobe,
  output calT    cal
);

  localparam logic [7:0] CENTURY_INIT = FOUR_DIGIT_YEAR ? 8'h20 : 8'h00;
  localparam calT CAL_INIT = '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h00,
                               mday: 8'h01, mon: 8'h01, yLo: 8'h00, yHi: CENTURY_INIT};

  calT  nxt;
  logic leapYear;
  logic minCarry, hourCarry, dayCarry, monCarry, yearCarry, centCarry;

  generate
    if (FOUR_DIGIT_YEAR) begin : g_leap4
      assign leapYear = (cal.yLo == 8'h00) ? bcdDiv4(cal.yHi) : bcdDiv4(cal.yLo);
    end else begin : g_leap2
      assign leapYear = bcdDiv4(cal.yLo);
    end
  endgenerate

  always_comb begin
    nxt       = cal;
    minCarry  = 1'b0;
    hourCarry = 1'b0;
    dayCarry  = 1'b0;
    monCarry  = 1'b0;
    yearCarry = 1'b0;
    centCarry = 1'b0;

    if (strobe.secTick) begin
      minCarry = (cal.sec >= 8'h59);
      nxt.sec  = minCarry ? 8'h00 : bcdInc(cal.sec);
    end else if (strobe.adjust) begin
      minCarry = (cal.sec >= 8'h30);
      nxt.sec  = 8'h00;
    end

    if (minCarry) begin
      hourCarry = (cal.min >= 8'h59);
      nxt.min   = hourCarry ? 8'h00 : bcdInc(cal.min);
    end

    if (hourCarry) begin
      dayCarry = (cal.hour >= 8'h23);
      nxt.hour = dayCarry ? 8'h00 : bcdInc(cal.hour);
    end

    if (dayCarry) begin
      nxt.wday = (cal.wday >= 8'h06) ? 8'h00 : bcdInc(cal.wday);
      monCarry = (cal.mday >= lastDay(cal.mon, leapYear));
      nxt.mday = monCarry ? 8'h01 : bcdInc(cal.mday);
    end

    if (monCarry) begin
      yearCarry = (cal.mon >= 8'h12);
      nxt.mon   = yearCarry ? 8'h01 : bcdInc(cal.mon);
    end

    if (yearCarry) begin
      centCarry = (cal.yLo >= 8'h99);
      nxt.yLo   = centCarry ? 8'h00 : bcdInc(cal.yLo);
    end

    if (FOUR_DIGIT_YEAR && centCarry) begin
      nxt.yHi = (cal.yHi >= 8'h99) ? 8'h00 : bcdInc(cal.yHi);
    end

    // direct load, only generated while stopped
    if (strobe.loadEn) begin
      case (strobe.loadSel)
        ADDR_SEC:     nxt.sec  = strobe.loadData;
        ADDR_MIN:     nxt.min  = strobe.loadData;
        ADDR_HOUR:    nxt.hour = strobe.loadData;
        ADDR_WDAY:    nxt.wday = strobe.loadData;
        ADDR_MDAY:    nxt.mday = strobe.loadData;
        ADDR_MON:     nxt.mon  = strobe.loadData;
        ADDR_YEAR_LO: nxt.yLo  = strobe.loadData;
        ADDR_YEAR_HI: if (FOUR_DIGIT_YEAR) nxt.yHi = strobe.loadData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cal <= CAL_INIT;
    else       cal <= nxt;
  end

endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE_DIV    = 256,
  parameter bit FOUR_DIGIT_YEAR = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData
);

  strobeT              strobe;
  calT                 cal;
  logic [SUBSEC_W-1:0] subSec;
  logic                carryFlag;
  logic                startBit;
  logic                validBit;

  rtc_ctrl #(
    .PRESCALE_DIV(PRESCALE_DIV)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strobe    (strobe),
    .subSec    (subSec),
    .carryFlag (carryFlag),
    .startBit  (startBit),
    .validBit  (validBit)
  );

  rtc_datapath #(
    .FOUR_DIGIT_YEAR(FOUR_DIGIT_YEAR)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cal    (cal)
  );

  always_comb begin
    case (regAddr)
      ADDR_SUBSEC:  regRdData = {{(8 - SUBSEC_W){1'b0}}, subSec};
      ADDR_SEC:     regRdData = cal.sec;
      ADDR_MIN:     regRdData = cal.min;
      ADDR_HOUR:    regRdData = cal.hour;
      ADDR_WDAY:    regRdData = cal.wday;
      ADDR_MDAY:    regRdData = cal.mday;
      ADDR_MON:     regRdData = cal.mon;
      ADDR_YEAR_LO: regRdData = cal.yLo;
      ADDR_YEAR_HI: regRdData = cal.yHi;
      ADDR_CTL1:    regRdData = {carryFlag, 7'd0};
      ADDR_CTL2:    regRdData = {4'd0, validBit, 2'b00, startBit};
      default:      regRdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
  import rtc_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [3:0]          regAddr,
  input logic                regWrEn,
  input logic                secTick,
  input logic                loadEn,
  input logic                startBit,
  input logic                carryFlag,
  input logic [SUBSEC_W-1:0] subSec,
  input logic [7:0]          secBcd,
  input logic [7:0]          minBcd,
  input logic [7:0]          hourBcd,
  input logic [7:0]          wdayBcd
);

  AST_CARRY_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> carryFlag); // R10

  AST_SUBSEC_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> (subSec == '0)); // R5

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && secBcd == 8'h59) |=> (secBcd == 8'h00)); // R6

  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && secBcd == 8'h59 && minBcd == 8'h59 && hourBcd == 8'h23 && wdayBcd == 8'h06)
      |=> (wdayBcd == 8'h00)); // R6

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!startBit && !regWrEn) |=> ($stable(secBcd) && $stable(minBcd) && $stable(subSec))); // R4

  AST_RUN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (startBit && regWrEn && regAddr == ADDR_SEC && !secTick) |=> $stable(secBcd)); // R3

  AST_LOAD_NOT_WITH_TICK: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |-> !secTick); // R3

endmodule

bind rtc_core rtc_core_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .secTick   (strobe.secTick),
  .loadEn    (strobe.loadEn),
  .startBit  (startBit),
  .carryFlag (carryFlag),
  .subSec    (subSec),
  .secBcd    (cal.sec),
  .minBcd    (cal.min),
  .hourBcd   (cal.hour),
  .wdayBcd   (cal.wday)
);

// File: tb/tb_rtc_core.sv
module tb_rtc_core;

  localparam int DIV    = 2;
  localparam int SECCYC = 128 * DIV;

  localparam logic [3:0] A_SUB = 4'd0,  A_SEC = 4'd1, A_MIN = 4'd2, A_HR = 4'd3;
  localparam logic [3:0] A_WDAY = 4'd4, A_MDAY = 4'd5, A_MON = 4'd6, A_YLO = 4'd7;
  localparam logic [3:0] A_YHI = 4'd8,  A_CTL1 = 4'd9, A_CTL2 = 4'd10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] addr = 4'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd, rd2;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  rtc_core #(.PRESCALE_DIV(DIV), .FOUR_DIGIT_YEAR(1'b1)) dut (
    .clk(clk), .rstN(rstN), .regAddr(addr), .regWrEn(wrEn), .regWrData(wd), .regRdData(rd));

  rtc_core #(.PRESCALE_DIV(DIV), .FOUR_DIGIT_YEAR(1'b0)) dut2 (
    .clk(clk), .rstN(rstN), .regAddr(addr), .regWrEn(wrEn), .regWrData(wd), .regRdData(rd2));

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wd = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdGet(input logic [3:0] a, output logic [7:0] v, output logic [7:0] v2);
    @(negedge clk);
    addr = a;
    #1;
    v = rd; v2 = rd2;
  endtask

  task automatic rdChk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v, v2;
    rdGet(a, v, v2);
    check(v, exp, tag);
  endtask

  task automatic rdChk2(input logic [3:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v, v2;
    rdGet(a, v, v2);
    check(v2, exp, tag);
  endtask

  task automatic setTime(input logic [7:0] yHi, input logic [7:0] yLo, input logic [7:0] mon,
                         input logic [7:0] mday, input logic [7:0] wday, input logic [7:0] hr,
                         input logic [7:0] mn, input logic [7:0] sc);
    wr(A_CTL2, 8'h02);
    wr(A_SEC, sc);  wr(A_MIN, mn);   wr(A_HR, hr);   wr(A_WDAY, wday);
    wr(A_MDAY, mday); wr(A_MON, mon); wr(A_YLO, yLo); wr(A_YHI, yHi);
  endtask

  // start with prescaler cleared, let one second pass, then stop
  task automatic runOneSecond();
    wr(A_CTL2, 8'h0B);
    repeat (SECCYC) @(negedge clk);
    wr(A_CTL2, 8'h08);
  endtask

  task automatic testReset();
    rdChk(A_SUB, 8'h00, "R1 subsec");
    rdChk(A_SEC, 8'h00, "R1 sec");
    rdChk(A_MIN, 8'h00, "R1 min");
    rdChk(A_HR, 8'h00, "R1 hour");
    rdChk(A_WDAY, 8'h00, "R1 wday");
    rdChk(A_MDAY, 8'h01, "R1 mday");
    rdChk(A_MON, 8'h01, "R1 month");
    rdChk(A_YLO, 8'h00, "R1 yearLo");
    rdChk(A_YHI, 8'h20, "R1 century");
    rdChk2(A_YHI, 8'h00, "R1 century two-digit");
    rdChk(A_CTL1, 8'h00, "R1 ctl1");
    rdChk(A_CTL2, 8'h00, "R1 ctl2");
  endtask

  task automatic testLoad();
    setTime(8'h20, 8'h24, 8'h07, 8'h15, 8'h03, 8'h12, 8'h34, 8'h56);
    rdChk(A_SEC, 8'h56, "R2 sec load");
    rdChk(A_MIN, 8'h34, "R2 min load");
    rdChk(A_HR, 8'h12, "R2 hour load");
    rdChk(A_WDAY, 8'h03, "R2 wday load");
    rdChk(A_MDAY, 8'h15, "R2 mday load");
    rdChk(A_MON, 8'h07, "R2 month load");
    rdChk(A_YLO, 8'h24, "R2 yearLo load");
    rdChk(A_YHI, 8'h20, "R2 century load");
    wr(A_CTL2, 8'h0A);
    rdChk(A_CTL2, 8'h08, "R12 valid stored, clear strobe reads 0");
  endtask

  task automatic testExactSecond();
    logic [7:0] v, v2;
    setTime(8'h20, 8'h24, 8'h03, 8'h10, 8'h01, 8'h08, 8'h00, 8'h10);
    wr(A_CTL2, 8'h0B);
    repeat (SECCYC - 2) @(negedge clk);
    rdChk(A_SEC, 8'h10, "R5 one edge before second");
    rdChk(A_SEC, 8'h11, "R5 second on exact edge");
    repeat (10 * DIV - 1) @(negedge clk);
    rdChk(A_SUB, 8'h0A, "R5 subsec rate");
    // stop and hold
    wr(A_CTL2, 8'h08);
    rdGet(A_SUB, v, v2);
    repeat (3 * SECCYC) @(negedge clk);
    rdChk(A_SUB, v, "R4 subsec holds while stopped");
    rdChk(A_SEC, 8'h11, "R4 seconds hold while stopped");
    wr(A_CTL2, 8'h0A);
    rdChk(A_SUB, 8'h00, "R5 prescaler clear");
  endtask

  task automatic testRunWriteIgnored();
    setTime(8'h20, 8'h24, 8'h03, 8'h10, 8'h01, 8'h08, 8'h00, 8'h30);
    wr(A_CTL2, 8'h0B);
    wr(A_SEC, 8'h05);
    wr(A_MON, 8'h09);
    rdChk(A_SEC, 8'h30, "R3 sec write while running");
    rdChk(A_MON, 8'h03, "R3 month write while running");
    rdChk(A_CTL2, 8'h09, "R12 start and valid read back");
    wr(A_CTL2, 8'h08);
  endtask

  task automatic testCascade();
    setTime(8'h20, 8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
    runOneSecond();
    rdChk(A_SEC, 8'h00, "R6 sec wrap");
    rdChk(A_MIN, 8'h00, "R6 min wrap");
    rdChk(A_HR, 8'h00, "R6 hour wrap");
    rdChk(A_WDAY, 8'h00, "R6 weekday 6 to 0");
    rdChk(A_MDAY, 8'h01, "R7 day 31 wrap");
    rdChk(A_MON, 8'h01, "R8 month 12 to 1");
    rdChk(A_YLO, 8'h00, "R8 yearLo 99 to 00");
    rdChk(A_YHI, 8'h21, "R8 century carry");
    rdChk2(A_YLO, 8'h00, "R9 two-digit 99 to 00");
    rdChk2(A_YHI, 8'h00, "R9 two-digit century reads 0");
    rdChk(A_CTL1, 8'h80, "R10 carry set after second");
  endtask

  task automatic testCarry();
    wr(A_CTL1, 8'h80);
    rdChk(A_CTL1, 8'h80, "R10 writing 1 keeps carry");
    wr(A_CTL1, 8'h7F);
    rdChk(A_CTL1, 8'h00, "R10 writing 0 clears carry");
  endtask

  task automatic dayRoll(input logic [7:0] yHi, input logic [7:0] yLo, input logic [7:0] mon,
                         input logic [7:0] mday, input logic [7:0] expMon,
                         input logic [7:0] expDay, input string tag);
    setTime(yHi, yLo, mon, mday, 8'h02, 8'h23, 8'h59, 8'h59);
    runOneSecond();
    rdChk(A_MON, expMon, {"R7 month ", tag});
    rdChk(A_MDAY, expDay, {"R7 day ", tag});
  endtask

  task automatic testMonths();
    dayRoll(8'h20, 8'h24, 8'h02, 8'h28, 8'h02, 8'h29, "2024-02-28");
    dayRoll(8'h20, 8'h24, 8'h02, 8'h29, 8'h03, 8'h01, "2024-02-29");
    dayRoll(8'h20, 8'h23, 8'h02, 8'h28, 8'h03, 8'h01, "2023-02-28");
    dayRoll(8'h20, 8'h00, 8'h02, 8'h28, 8'h02, 8'h29, "2000-02-28");
    dayRoll(8'h21, 8'h00, 8'h02, 8'h28, 8'h03, 8'h01, "2100-02-28");
    rdChk2(A_MDAY, 8'h29, "R9 two-digit 00 is leap");
    dayRoll(8'h20, 8'h24, 8'h04, 8'h29, 8'h04, 8'h30, "04-29");
    dayRoll(8'h20, 8'h24, 8'h04, 8'h30, 8'h05, 8'h01, "04-30");
    dayRoll(8'h20, 8'h24, 8'h01, 8'h31, 8'h02, 8'h01, "01-31");
    dayRoll(8'h20, 8'h24, 8'h11, 8'h30, 8'h12, 8'h01, "11-30");
  endtask

  task automatic testAdjust();
    setTime(8'h20, 8'h24, 8'h05, 8'h05, 8'h01, 8'h05, 8'h10, 8'h25);
    wr(A_CTL2, 8'h04);
    rdChk(A_SEC, 8'h00, "R11 adjust low half sec");
    rdChk(A_MIN, 8'h10, "R11 adjust low half min");
    rdChk(A_CTL2, 8'h00, "R12 adjust strobe reads 0");
    wr(A_SEC, 8'h45);
    wr(A_MIN, 8'h59);
    wr(A_CTL2, 8'h04);
    rdChk(A_SEC, 8'h00, "R11 adjust high half sec");
    rdChk(A_MIN, 8'h00, "R11 adjust high half min");
    rdChk(A_HR, 8'h06, "R11 adjust carry to hour");
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLoad();
    testExactSecond();
    testRunWriteIgnored();
    testCascade();
    testCarry();
    testMonths();
    testAdjust();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule